// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block generates the digital drive pattern for a segment LCD whose backplanes are time-multiplexed. A selected reference tick, from either a fast or a slow clock source, is divided down to a frame base rate. The block then steps through one time slot per active common line. Each slot has a positive phase followed by a negative phase, so every pin averages to zero DC. For every common (COM) and segment (SEG) pin it registers a 2-bit drive-level code and an output enable. An analog stage outside the block maps codes 0..3 to bias voltages, from the lowest (0) to the highest (3).

Software writes a 7-bit control word and a small segment-data array, with one row per common line. The duty/bias mode, the frame-rate tap and the reference select are frozen while the display runs. A stop-mode request drops the enable in hardware. When disabled, the pins fall to defined safe states.

Top module: `lcd_wave_seq`

## Requirements
- R1: The control word has en at bit 0, mode at bits 2:1, rate select at bits 4:3, fast-reference select at bit 5 and SEG force at bit 6. Mode 0 gives 4 slots at 1/3 bias, mode 1 gives 3 slots at 1/3 bias, mode 2 gives 2 slots at 1/2 bias, and mode 3 gives 1 slot (static). Slots run 0,1,..,n-1 and then wrap, each as phase 0 followed by phase 1. The enable write starts at slot 0, phase 0.
- R2: When enabled at 1/3 bias: the selected COM drives 3 in phase 0 and 0 in phase 1, and unselected COMs drive 1 then 2. A SEG whose data bit in the current slot's row is 1 drives 0 then 3. A SEG whose bit is 0 drives 2 then 1.
- R3: When enabled at 1/2 bias or static: the selected COM drives 3 then 0, and unselected COMs drive 1 in both phases. A SEG with data 1 drives 0 then 3. A SEG with data 0 drives 3 then 0.
- R4: Mode, rate select and fast-reference select accept a write only if en was already 0 before the write. A write that clears en while the display runs leaves them unchanged.
- R5: A stop request clears en at the next clock edge. It overrides a simultaneous write that sets en.
- R6: A write that selects the fast reference while the system-clock-slow input is 1 leaves that bit at its previous value.
- R7: Each rate select picks a tap t from the table for the chosen reference. The sequencer advances one phase per 2^t ticks of the chosen reference. Ticks of the other reference have no effect.
- R8: While disabled, every COM has enable 1 and level 0, and every SEG has enable 0 and level 0.
- R9: While disabled with the force bit at 1, SEG pins below FORCE_SEGS have enable 1 and level 0.
- R10: While enabled, COM lines at or above the active slot count have enable 0 and level 0.
- R11: After reset the control word reads 0 and the pins are in the disabled state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_wdata | input | 7 | Control word to write |
| cfg_rdata | output | 7 | Current control word |
| seg_we | input | 1 | Segment-row write strobe |
| seg_row | input | 2 | Row (COM index) to write |
| seg_wdata | input | NUM_SEG | Segment data bits for the row |
| sys_clk_slow | input | 1 | System clock currently runs from the slow source |
| stop_req | input | 1 | Stop-mode request |
| ref_tick_hi | input | 1 | Fast-reference tick |
| ref_tick_lo | input | 1 | Slow-reference tick |
| com_level | output | 8 | Level code per COM, 2 bits each |
| com_oe | output | 4 | Drive enable per COM |
| seg_level | output | 2*NUM_SEG | Level code per SEG, 2 bits each |
| seg_oe | output | NUM_SEG | Drive enable per SEG |

## Verification
A control write takes effect in the register at the write edge. The pins reflect it one edge later. A reference tick sampled at an edge moves the slot and phase at that edge, and the pins show the new state one edge after that. Every bench task therefore waits one full extra cycle after the strobe and compares at the falling edge. The divider windows are checked by counting ticks: the state must not change through tick 2^t-1 and must change at tick 2^t.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int NUM_COM   = 4;
  localparam int COM_IDX_W = 2;
  localparam int TAP_W     = 5;
  localparam int CTRL_W    = 7;

  typedef enum logic [1:0] {
    DUTY_QUARTER = 2'd0,
    DUTY_THIRD   = 2'd1,
    DUTY_HALF    = 2'd2,
    DUTY_STATIC  = 2'd3
  } duty_e;

  typedef struct packed {
    logic       seg_force;
    logic       ref_hi;
    logic [1:0] fsel;
    duty_e      duty;
    logic       en;
  } ctrl_t;

  localparam logic [1:0] LV_0 = 2'd0;
  localparam logic [1:0] LV_1 = 2'd1;
  localparam logic [1:0] LV_2 = 2'd2;
  localparam logic [1:0] LV_3 = 2'd3;

  function automatic logic [2:0] slots_of(duty_e d);
    case (d)
      DUTY_QUARTER: slots_of = 3'd4;
      DUTY_THIRD:   slots_of = 3'd3;
      DUTY_HALF:    slots_of = 3'd2;
      default:      slots_of = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/lcd_ctrl_reg.sv
module lcd_ctrl_reg
  import lcd_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cfg_we,
  input  ctrl_t wr,
  input  logic  sys_clk_slow,
  input  logic  stop_req,
  output ctrl_t ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (cfg_we) begin
        ctrl_q.en        <= wr.en;
        ctrl_q.seg_force <= wr.seg_force;
        if (!ctrl_q.en) begin
          ctrl_q.duty <= wr.duty;
          ctrl_q.fsel <= wr.fsel;
          if (!(wr.ref_hi && sys_clk_slow))
            ctrl_q.ref_hi <= wr.ref_hi;
        end
      end
      if (stop_req)
        ctrl_q.en <= 1'b0;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ctrl_q.en |=> $stable({ctrl_q.duty, ctrl_q.fsel, ctrl_q.ref_hi})); // R4
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> !ctrl_q.en); // R5
  AST_NO_FAST_ON_SLOW: assert property (@(posedge clk) disable iff (rst)
    (sys_clk_slow && !ctrl_q.ref_hi) |=> !ctrl_q.ref_hi); // R6
endmodule

// File: rtl/lcd_frame_div.sv
module lcd_frame_div
  import lcd_seq_pkg::*;
#(
  parameter int                     CNT_W   = 20,
  parameter logic [4*TAP_W-1:0]     HI_TAPS = {5'd16, 5'd17, 5'd18, 5'd19},
  parameter logic [4*TAP_W-1:0]     LO_TAPS = {5'd7, 5'd8, 5'd9, 5'd10}
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       ref_hi,
  input  logic [1:0] fsel,
  input  logic       ref_tick_hi,
  input  logic       ref_tick_lo,
  output logic       base_tick
);
  logic [TAP_W-1:0] tap;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt_q;
  logic             tick_sel;

  always_comb begin
    tap      = ref_hi ? HI_TAPS[int'(fsel)*TAP_W +: TAP_W]
                      : LO_TAPS[int'(fsel)*TAP_W +: TAP_W];
    tick_sel = ref_hi ? ref_tick_hi : ref_tick_lo;
    mask     = ~({CNT_W{1'b1}} << tap);
    base_tick = en && tick_sel && ((cnt_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) cnt_q <= '0;
    else if (tick_sel) cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    (base_tick && tap != '0) |=> !base_tick); // R7
endmodule

// File: rtl/lcd_slot_seq.sv
module lcd_slot_seq
  import lcd_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  duty_e                duty,
  input  logic                 base_tick,
  output logic [COM_IDX_W-1:0] slot_q,
  output logic                 phase_q
);
  logic [2:0] nslots;
  assign nslots = slots_of(duty);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      slot_q  <= '0;
      phase_q <= 1'b0;
    end else if (base_tick) begin
      if (phase_q) begin
        phase_q <= 1'b0;
        if ({1'b0, slot_q} + 3'd1 == nslots) slot_q <= '0;
        else slot_q <= slot_q + 1'b1;
      end else begin
        phase_q <= 1'b1;
      end
    end
  end

  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, slot_q} < nslots)); // R1
  AST_IDLE_HOME: assert property (@(posedge clk) disable iff (rst)
    !en |=> (slot_q == '0 && !phase_q)); // R1
endmodule

// File: rtl/lcd_pin_drive.sv
module lcd_pin_drive
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG    = 16,
  parameter int FORCE_SEGS = 8
)(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  duty_e                  duty,
  input  logic                   seg_force,
  input  logic [COM_IDX_W-1:0]   slot,
  input  logic                   phase,
  input  logic                   seg_we,
  input  logic [COM_IDX_W-1:0]   seg_row,
  input  logic [NUM_SEG-1:0]     seg_wdata,
  output logic [2*NUM_COM-1:0]   com_level,
  output logic [NUM_COM-1:0]     com_oe,
  output logic [2*NUM_SEG-1:0]   seg_level,
  output logic [NUM_SEG-1:0]     seg_oe
);
  logic [NUM_SEG-1:0] seg_mem [NUM_COM];
  logic [NUM_SEG-1:0] row;
  logic [2:0]         nslots;
  logic               third;

  always_ff @(posedge clk) begin
    if (seg_we) seg_mem[seg_row] <= seg_wdata;
  end

  assign row    = seg_mem[slot];
  assign nslots = slots_of(duty);
  assign third  = (duty == DUTY_QUARTER) || (duty == DUTY_THIRD);

  for (genvar gi = 0; gi < NUM_COM; gi++) begin : g_com
    always_ff @(posedge clk) begin
      if (rst || !en) begin
        com_oe[gi]           <= 1'b1;
        com_level[2*gi +: 2] <= LV_0;
      end else if (3'(gi) >= nslots) begin
        com_oe[gi]           <= 1'b0;
        com_level[2*gi +: 2] <= LV_0;
      end else begin
        com_oe[gi] <= 1'b1;
        if (slot == COM_IDX_W'(gi))
          com_level[2*gi +: 2] <= phase ? LV_0 : LV_3;
        else if (third)
          com_level[2*gi +: 2] <= phase ? LV_2 : LV_1;
        else
          com_level[2*gi +: 2] <= LV_1;
      end
    end
  end

  for (genvar gj = 0; gj < NUM_SEG; gj++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst || !en) begin
        seg_oe[gj]           <= (gj < FORCE_SEGS) && seg_force && !rst;
        seg_level[2*gj +: 2] <= LV_0;
      end else begin
        seg_oe[gj] <= 1'b1;
        if (third)
          seg_level[2*gj +: 2] <= phase ? (row[gj] ? LV_3 : LV_1)
                                        : (row[gj] ? LV_0 : LV_2);
        else
          seg_level[2*gj +: 2] <= phase ? (row[gj] ? LV_3 : LV_0)
                                        : (row[gj] ? LV_0 : LV_3);
      end
    end
  end

  AST_OFF_PINS_SAFE: assert property (@(posedge clk) disable iff (rst)
    !en |=> (com_oe == '1 && com_level == '0 && seg_level == '0)); // R8
  AST_FORCE_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (!en && seg_force) |=> (seg_oe[FORCE_SEGS-1:0] == '1)); // R9
endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq
  import lcd_seq_pkg::*;
#(
  parameter int                 NUM_SEG    = 16,
  parameter int                 FORCE_SEGS = 8,
  parameter int                 CNT_W      = 20,
  parameter logic [4*TAP_W-1:0] HI_TAPS    = {5'd16, 5'd17, 5'd18, 5'd19},
  parameter logic [4*TAP_W-1:0] LO_TAPS    = {5'd7, 5'd8, 5'd9, 5'd10}
)(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [CTRL_W-1:0]      cfg_wdata,
  output logic [CTRL_W-1:0]      cfg_rdata,
  input  logic                   seg_we,
  input  logic [COM_IDX_W-1:0]   seg_row,
  input  logic [NUM_SEG-1:0]     seg_wdata,
  input  logic                   sys_clk_slow,
  input  logic                   stop_req,
  input  logic                   ref_tick_hi,
  input  logic                   ref_tick_lo,
  output logic [2*NUM_COM-1:0]   com_level,
  output logic [NUM_COM-1:0]     com_oe,
  output logic [2*NUM_SEG-1:0]   seg_level,
  output logic [NUM_SEG-1:0]     seg_oe
);
  ctrl_t                wr;
  ctrl_t                ctrl;
  logic                 base_tick;
  logic [COM_IDX_W-1:0] slot;
  logic                 phase;

  assign wr        = ctrl_t'(cfg_wdata);
  assign cfg_rdata = CTRL_W'(ctrl);

  lcd_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .wr(wr),
    .sys_clk_slow(sys_clk_slow), .stop_req(stop_req), .ctrl_q(ctrl)
  );

  lcd_frame_div #(.CNT_W(CNT_W), .HI_TAPS(HI_TAPS), .LO_TAPS(LO_TAPS)) u_div (
    .clk(clk), .rst(rst), .en(ctrl.en), .ref_hi(ctrl.ref_hi), .fsel(ctrl.fsel),
    .ref_tick_hi(ref_tick_hi), .ref_tick_lo(ref_tick_lo), .base_tick(base_tick)
  );

  lcd_slot_seq u_seq (
    .clk(clk), .rst(rst), .en(ctrl.en), .duty(ctrl.duty),
    .base_tick(base_tick), .slot_q(slot), .phase_q(phase)
  );

  lcd_pin_drive #(.NUM_SEG(NUM_SEG), .FORCE_SEGS(FORCE_SEGS)) u_pins (
    .clk(clk), .rst(rst), .en(ctrl.en), .duty(ctrl.duty), .seg_force(ctrl.seg_force),
    .slot(slot), .phase(phase), .seg_we(seg_we), .seg_row(seg_row),
    .seg_wdata(seg_wdata), .com_level(com_level), .com_oe(com_oe),
    .seg_level(seg_level), .seg_oe(seg_oe)
  );
endmodule

// File: tb/lcd_wave_seq_test.sv
module lcd_wave_seq_test;
  localparam int NS = 16;
  localparam int NF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic [6:0] cfg_rdata;
  logic seg_we = 1'b0;
  logic [1:0] seg_row = '0;
  logic [NS-1:0] seg_wdata = '0;
  logic sys_clk_slow = 1'b0;
  logic stop_req = 1'b0;
  logic ref_tick_hi = 1'b0;
  logic ref_tick_lo = 1'b0;
  logic [7:0] com_level;
  logic [3:0] com_oe;
  logic [2*NS-1:0] seg_level;
  logic [NS-1:0] seg_oe;

  int total = 0;
  int bad = 0;
  logic [NS-1:0] rows [4];

  always #2.5 clk = ~clk;

  lcd_wave_seq #(.NUM_SEG(NS), .FORCE_SEGS(NF), .CNT_W(8),
    .HI_TAPS({5'd2, 5'd3, 5'd4, 5'd5}), .LO_TAPS({5'd0, 5'd1, 5'd2, 5'd3})) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .seg_we(seg_we), .seg_row(seg_row), .seg_wdata(seg_wdata),
    .sys_clk_slow(sys_clk_slow), .stop_req(stop_req),
    .ref_tick_hi(ref_tick_hi), .ref_tick_lo(ref_tick_lo),
    .com_level(com_level), .com_oe(com_oe), .seg_level(seg_level), .seg_oe(seg_oe));

  typedef struct {
    string           rq;
    logic [7:0]      cl;
    logic [3:0]      co;
    logic [2*NS-1:0] sl;
    logic [NS-1:0]   so;
  } exp_t;
  exp_t q[$];
  event chk_ev;

  function automatic logic [6:0] mk(int en, int duty, int fsel, int hi, int frc);
    return {frc[0], hi[0], fsel[1:0], duty[1:0], en[0]};
  endfunction

  // scoreboard driver side: model from the requirements
  task automatic expect_pins(string rq, int duty, int slot, int ph, bit en, bit frc);
    exp_t e;
    int n;
    bit third;
    n = (duty == 0) ? 4 : (duty == 1) ? 3 : (duty == 2) ? 2 : 1;
    third = (duty < 2);
    e.rq = rq;
    for (int i = 0; i < 4; i++) begin
      if (!en) begin e.co[i] = 1'b1; e.cl[2*i +: 2] = 2'd0; end        // R8
      else if (i >= n) begin e.co[i] = 1'b0; e.cl[2*i +: 2] = 2'd0; end // R10
      else begin
        e.co[i] = 1'b1;
        if (i == slot) e.cl[2*i +: 2] = ph ? 2'd0 : 2'd3;
        else if (third) e.cl[2*i +: 2] = ph ? 2'd2 : 2'd1;             // R2
        else e.cl[2*i +: 2] = 2'd1;                                    // R3
      end
    end
    for (int j = 0; j < NS; j++) begin
      if (!en) begin e.so[j] = frc && (j < NF); e.sl[2*j +: 2] = 2'd0; end // R9
      else begin
        e.so[j] = 1'b1;
        if (third) e.sl[2*j +: 2] = ph ? (rows[slot][j] ? 2'd3 : 2'd1) : (rows[slot][j] ? 2'd0 : 2'd2);
        else e.sl[2*j +: 2] = ph ? (rows[slot][j] ? 2'd3 : 2'd0) : (rows[slot][j] ? 2'd0 : 2'd3);
      end
    end
    q.push_back(e);
    -> chk_ev;
  endtask

  // scoreboard monitor side
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (com_level !== e.cl || com_oe !== e.co || seg_level !== e.sl || seg_oe !== e.so) begin
          bad++;
          $display("FAIL %s: got com=%h/%h seg=%h/%h exp com=%h/%h seg=%h/%h", e.rq,
            com_level, com_oe, seg_level, seg_oe, e.cl, e.co, e.sl, e.so);
        end
      end
    end
  end

  task automatic check_reg(string rq, logic [6:0] exp);
    total++;
    if (cfg_rdata !== exp) begin
      bad++;
      $display("FAIL %s: cfg_rdata got %h exp %h", rq, cfg_rdata, exp);
    end
  endtask

  task automatic wr_cfg(logic [6:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic tick(bit hi);
    @(negedge clk); if (hi) ref_tick_hi = 1'b1; else ref_tick_lo = 1'b1;
    @(negedge clk); ref_tick_hi = 1'b0; ref_tick_lo = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_frame(int duty);
    int n;
    n = (duty == 0) ? 4 : (duty == 1) ? 3 : (duty == 2) ? 2 : 1;
    wr_cfg(mk(1, duty, 3, 0, 0));
    expect_pins("R1 frame start", duty, 0, 0, 1'b1, 1'b0);
    for (int k = 1; k <= 2*n; k++) begin
      tick(1'b0);
      expect_pins(duty < 2 ? "R1 R2 frame step" : "R1 R3 frame step", duty, (k/2) % n, k % 2, 1'b1, 1'b0);
    end
    wr_cfg(mk(0, duty, 3, 0, 0));
    expect_pins("R8 disabled after frame", duty, 0, 0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got running exp finished");
    finish_run();
  end

  initial begin
    rows[0] = 16'hA5C3; rows[1] = 16'h0FF0; rows[2] = 16'h3C96; rows[3] = 16'hF00F;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reg("R11 reset word", 7'h00);
    expect_pins("R11 reset pins", 0, 0, 0, 1'b0, 1'b0);

    for (int r = 0; r < 4; r++) begin
      @(negedge clk); seg_we = 1'b1; seg_row = r[1:0]; seg_wdata = rows[r];
    end
    @(negedge clk); seg_we = 1'b0;

    for (int d = 0; d < 4; d++) run_frame(d);

    // R4: locked configuration while running
    wr_cfg(mk(1, 0, 3, 0, 0));
    wr_cfg(mk(1, 2, 0, 1, 0));
    check_reg("R4 write ignored while on", mk(1, 0, 3, 0, 0));
    tick(1'b0);
    expect_pins("R4 still mode 0", 0, 0, 1, 1'b1, 1'b0);
    tick(1'b0); tick(1'b0); tick(1'b0);
    expect_pins("R4 third slot reached", 0, 2, 0, 1'b1, 1'b0);
    wr_cfg(mk(0, 2, 0, 0, 0));
    check_reg("R4 clear with change ignored", mk(0, 0, 3, 0, 0));
    expect_pins("R8 off after clear", 0, 0, 0, 1'b0, 1'b0);

    // R5: stop request
    wr_cfg(mk(1, 1, 3, 0, 0));
    check_reg("R4 accepted while off", mk(1, 1, 3, 0, 0));
    tick(1'b0);
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    @(negedge clk);
    check_reg("R5 stop clears en", mk(0, 1, 3, 0, 0));
    expect_pins("R5 R8 pins after stop", 1, 0, 0, 1'b0, 1'b0);
    @(negedge clk); stop_req = 1'b1; cfg_we = 1'b1; cfg_wdata = mk(1, 1, 3, 0, 0);
    @(negedge clk); stop_req = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    check_reg("R5 stop beats enable write", mk(0, 1, 3, 0, 0));

    // R9: force bit
    wr_cfg(mk(0, 1, 3, 0, 1));
    expect_pins("R9 forced seg low", 1, 0, 0, 1'b0, 1'b1);
    wr_cfg(mk(0, 1, 3, 0, 0));
    expect_pins("R8 force released", 1, 0, 0, 1'b0, 1'b0);

    // R6: fast reference refused on slow system clock
    sys_clk_slow = 1'b1;
    wr_cfg(mk(0, 0, 3, 1, 0));
    check_reg("R6 fast ref refused", mk(0, 0, 3, 0, 0));
    sys_clk_slow = 1'b0;
    wr_cfg(mk(0, 0, 3, 1, 0));
    check_reg("R6 fast ref accepted", mk(0, 0, 3, 1, 0));

    // R7: fast reference, select 3 -> tap 2
    wr_cfg(mk(1, 0, 3, 1, 0));
    tick(1'b1); tick(1'b1); tick(1'b1);
    expect_pins("R7 fast 3 ticks no step", 0, 0, 0, 1'b1, 1'b0);
    tick(1'b0); tick(1'b0);
    expect_pins("R7 slow ticks ignored", 0, 0, 0, 1'b1, 1'b0);
    tick(1'b1);
    expect_pins("R7 fast 4th tick steps", 0, 0, 1, 1'b1, 1'b0);
    wr_cfg(mk(0, 0, 3, 1, 0));

    // R7: slow reference, select 1 -> tap 2
    wr_cfg(mk(1, 0, 1, 0, 0));
    tick(1'b0); tick(1'b1); tick(1'b0); tick(1'b0);
    expect_pins("R7 slow 3 ticks no step", 0, 0, 0, 1'b1, 1'b0);
    tick(1'b0);
    expect_pins("R7 slow 4th tick steps", 0, 0, 1, 1'b1, 1'b0);
    wr_cfg(mk(0, 0, 1, 0, 0));
    expect_pins("R8 final off", 0, 0, 0, 1'b0, 1'b0);

    @(negedge clk);
    finish_run();
  end
endmodule